// File: doc/BRIEF.md
# Truncated One-Hot Stepper Phase Sequencer

This block drives the windings of a unipolar stepper motor from a single step clock. Inside is a switch-tail shift register of five stages, which gives ten distinct states. Each state is decoded into one line of a one-hot output bus. Every clock on which the enable is high moves the active line one position along.

The cycle is cut short at a terminal count chosen by a phase-count select input, so only the first three or the first four lines are used in turn. The cut is synchronous. The register goes straight from the last used count back to count 0, and the terminal count never shows on any line, even briefly.

The lines only need to be asserted or deasserted, because a unipolar drive never reverses polarity. External drivers switch the windings from these lines. A change of the select waits for the next wrap to count 0, so a sequence that has already started is never broken off.

Top module: `stepper_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next output is `step == 10'b00_0000_0001`: only bit 0 (count 0) is active, and the select is sampled as the mode.
- R2: Outside reset, exactly one bit of `step` is high in every cycle.
- R3: With the mode at 3 phases (`four_phase == 0`), each enabled clock moves the active bit 0 -> 1 -> 2 -> 0. Each bit stays active for one clock period.
- R4: With the mode at 4 phases (`four_phase == 1`), each enabled clock moves the active bit 0 -> 1 -> 2 -> 3 -> 0.
- R5: Bits 4 to 9 of `step` are never high. In 3-phase mode bit 3 is never high either: the terminal count is never output, not even for one cycle.
- R6: When `en` is low at a clock edge (and `rst` is low), `step` keeps its value.
- R7: A new value of `four_phase` is taken as the mode only at reset or on the enabled clock that wraps the count to 0. Between wraps the mode in use does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Step clock; each enabled rising edge advances one step |
| rst | input | 1 | Synchronous active-high reset to count 0 |
| en | input | 1 | Advance enable; low holds the current step |
| four_phase | input | 1 | Phase-count select: 0 = 3 phases, 1 = 4 phases |
| step | output | 10 | Registered one-hot winding lines, bit k = count k |

## Verification
Directed runs in each mode check the exact order of the lines and the wrap point. Together they show that 3-phase and 4-phase truncation differ, and that no terminal count slips out. A run with the enable held low separates a true hold from a free-running count. A select flip in the middle of a cycle shows whether the mode change waits for the wrap or is taken at once. A long constrained-random stream mixes the enable, the select and occasional resets. It exposes any ordering in which the one-hot property breaks or the mode latch and the counter drift apart.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

  typedef enum logic {
    MODE_3PH = 1'b0,
    MODE_4PH = 1'b1
  } phase_mode_e;

  localparam int unsigned LAST_3PH = 2;
  localparam int unsigned LAST_4PH = 3;

endpackage

// File: rtl/switch_tail_core.sv
module switch_tail_core #(
  parameter int unsigned STAGES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wrap,
  output logic [STAGES-1:0] nxt
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] shifted;

  // stage 0 takes the inverted last stage; the others shift along
  assign shifted = {stage_q[STAGES-2:0], ~stage_q[STAGES-1]};

  always_comb begin
    if (rst || wrap) nxt = '0;
    else if (en)     nxt = shifted;
    else             nxt = stage_q;
  end

  always_ff @(posedge clk) begin
    stage_q <= nxt;
  end

endmodule

// File: rtl/switch_tail_decode.sv
module switch_tail_decode #(
  parameter int unsigned STAGES  = 5,
  localparam int unsigned NUM_OUT = 2 * STAGES
) (
  input  logic [STAGES-1:0]  stages,
  output logic [NUM_OUT-1:0] lines
);

  // every state is picked out by a two-input gate on adjacent stages
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_dec
    if (k == 0) begin : g_first
      assign lines[k] = ~stages[0] & ~stages[STAGES-1];
    end else if (k < STAGES) begin : g_fill
      assign lines[k] = stages[k-1] & ~stages[k];
    end else if (k == STAGES) begin : g_full
      assign lines[k] = stages[0] & stages[STAGES-1];
    end else begin : g_drain
      assign lines[k] = ~stages[k-STAGES-1] & stages[k-STAGES];
    end
  end

endmodule

// File: rtl/wrap_ctrl.sv
module wrap_ctrl
  import stepper_pkg::*;
#(
  parameter int unsigned NUM_OUT = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               four_phase,
  input  logic [NUM_OUT-1:0] cur,
  output logic               wrap
);

  phase_mode_e mode_q;
  logic        at_last;

  assign at_last = (mode_q == MODE_4PH) ? cur[LAST_4PH] : cur[LAST_3PH];
  assign wrap    = en & at_last & ~rst;

  always_ff @(posedge clk) begin
    if (rst || wrap) mode_q <= phase_mode_e'(four_phase);
  end

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(mode_q)); // R7

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap |=> cur[0]); // R3

endmodule

// File: rtl/stepper_seq.sv
module stepper_seq #(
  parameter int unsigned STAGES  = 5,
  localparam int unsigned NUM_OUT = 2 * STAGES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               four_phase,
  output logic [NUM_OUT-1:0] step
);

  logic [STAGES-1:0]  nxt;
  logic [NUM_OUT-1:0] nxt_lines;
  logic               wrap;

  switch_tail_core #(.STAGES(STAGES)) u_core (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .wrap(wrap),
    .nxt (nxt)
  );

  switch_tail_decode #(.STAGES(STAGES)) u_dec (
    .stages(nxt),
    .lines (nxt_lines)
  );

  wrap_ctrl #(.NUM_OUT(NUM_OUT)) u_wrap (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .four_phase(four_phase),
    .cur       (step),
    .wrap      (wrap)
  );

  // registered lines always equal the decode of the stage register
  always_ff @(posedge clk) begin
    step <= nxt_lines;
  end

  AST_RESET_Q0: assert property (@(posedge clk)
    rst |=> (step == NUM_OUT'(1))); // R1

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    $countones(step) == 1); // R2

  AST_UPPER_LOW: assert property (@(posedge clk) disable iff (rst)
    step[NUM_OUT-1:4] == '0); // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(step)); // R6

  AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (en && step[0]) |=> step[1]); // R4

endmodule

// File: tb/stepper_seq_tb.sv
module stepper_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       four_phase = 1'b0;
  logic [9:0] step;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int m_cnt  = 0;
  bit m_four = 1'b0;

  always #5 clk = ~clk;

  stepper_seq u_dut (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .four_phase(four_phase),
    .step      (step)
  );

  function automatic logic [9:0] exp_lines(int c);
    return 10'(1) << c;
  endfunction

  task automatic check(string req, logic [9:0] expv);
    checks++;
    if (step !== expv) begin
      fails++;
      $display("FAIL %s: step=%b expected=%b", req, step, expv);
    end
  endtask

  // one clock: model follows the requirements, then compare away from the edge
  task automatic tick(string req);
    @(posedge clk);
    if (rst) begin
      m_cnt  = 0;
      m_four = four_phase;
    end else if (en) begin
      if (m_cnt == (m_four ? 3 : 2)) begin
        m_cnt  = 0;
        m_four = four_phase;
      end else begin
        m_cnt++;
      end
    end
    @(negedge clk);
    check(req, exp_lines(m_cnt));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: step=%b expected=run complete", step);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7717));
    @(negedge clk);
    rst = 1'b1; four_phase = 1'b0; en = 1'b1;
    tick("R1 reset");
    rst = 1'b0;

    for (int i = 0; i < 7; i++) tick("R3 three-phase order");

    four_phase = 1'b1;
    while (m_cnt != 0) tick("R7 wait wrap");
    for (int i = 0; i < 9; i++) tick("R4 four-phase order");

    en = 1'b0;
    for (int i = 0; i < 4; i++) tick("R6 hold");
    en = 1'b1;

    rst = 1'b1; four_phase = 1'b0;
    tick("R1 reset mode 3");
    rst = 1'b0;
    tick("R7 pre");
    four_phase = 1'b1;
    tick("R7 old mode count 2");
    tick("R7 wrap at 3-phase end");
    for (int i = 0; i < 4; i++) tick("R7 new mode takes 4 phases");

    four_phase = 1'b0;
    for (int i = 0; i < 5; i++) tick("R5 no terminal count");

    for (int i = 0; i < 3000; i++) begin
      en         = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 9) == 0) four_phase = ~four_phase;
      rst        = ($urandom_range(0, 99) == 0);
      tick("R2 R5 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule